// File: doc/BRIEF.md
# Fail-Safe Device Mode Controller

This block keeps track of the operating mode of a serially controlled output-driver chip. It has four modes: power-down, standby, fail-safe and normal. Loss of the core supply or a low enable pin pushes the chip into a clearing state. When both return, the chip comes up in fail-safe. In fail-safe the external power stages fall back to their limp-home level. The block releases control of them and forces the sync output high.

Normal mode needs two things to start: a written limp-home control bit, and proof that the host is alive. The host must produce a chip-select rising edge within a window picked by a 2-bit code. The window is counted in system clocks. If the window runs out, the block drops back to fail-safe and clears the limp-home bit. A software reset, a read of the reserved reset address, or a data line stuck low does the same. A sticky reset-status bit records that a clearing event happened, and reading it clears it.

Top module: `safemode_ctrl`

## Requirements
- R1: While `supply_ok` is low, `mode` becomes 0 (power-down) on the next clock, whatever `en_pin` is; `reg_clear` is high and `lh_bit` is 0.
- R2: With `supply_ok` high and `en_pin` low, `mode` becomes 1 (standby) on the next clock, with `reg_clear` high and `lh_bit` 0.
- R3: From power-down or standby, with `supply_ok` and `en_pin` both high, `mode` becomes 2 (fail-safe) one clock later, and `reg_clear` drops.
- R4: A write (`lh_wr`) of `lh_val`=1 in fail-safe enters normal (`mode` 3) and sets `lh_bit`. A write of 0 in normal returns to fail-safe and clears `lh_bit`.
- R5: In normal with no `cs_rise`, the mode stays 3 for exactly WIN_k clocks, where k = `tmo_sel` (0..3 picks WIN0..WIN3). `tmo_evt` is high in the last of those clocks; then `mode` is 2 and `lh_bit` is 0. Each `cs_rise` restarts the full window.
- R6: `swrst_req`, or `rd_stb` with `rd_addr` equal to RST_ADDR (0x3F by default), in fail-safe or normal gives mode 2 with `lh_bit` 0 and `rst_flag` 1. `reg_clear` is high for exactly one clock. A read of any other address has no effect.
- R7: `sdi_stuck_lo` in fail-safe or normal gives mode 2 with `lh_bit` 0, and leaves `rst_flag` unchanged.
- R8: `lh_pin` is 1 only in mode 3. `out_release` is 1 in modes 0, 1 and 2. `sync_force_hi` is 1 only in mode 2.
- R9: `rst_flag` is 1 after reset, power-down, standby or software reset. `status_rd` clears it, and entering normal does not.
- R10: Priority, highest first: software reset, stuck data line, timeout, limp-home write. When set and clear of `rst_flag` coincide, set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Core supply above reset threshold |
| en_pin | input | 1 | Enable pin level |
| lh_wr | input | 1 | Write strobe for the limp-home bit |
| lh_val | input | 1 | Value written to the limp-home bit |
| cs_rise | input | 1 | One-clock pulse per chip-select rising edge |
| swrst_req | input | 1 | Software reset request |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | AW | Register read address |
| status_rd | input | 1 | Reset-status bit is being read |
| sdi_stuck_lo | input | 1 | Serial data input detected stuck low |
| tmo_sel | input | 2 | Watchdog window code |
| mode | output | 2 | 0 power-down, 1 standby, 2 fail-safe, 3 normal |
| reg_clear | output | 1 | Register clear request |
| out_release | output | 1 | Driver outputs released (high impedance) |
| lh_pin | output | 1 | Limp-home pin level |
| lh_bit | output | 1 | Current limp-home control bit |
| rst_flag | output | 1 | Sticky reset-status bit |
| sync_force_hi | output | 1 | Force sync output high |
| tmo_evt | output | 1 | Watchdog expiry in this clock |

## Verification
The watchdog is swept over all four window codes with no chip-select activity. Counting the clocks spent in normal shows whether each code picks the right count, and whether there is an off-by-one at expiry. A keep-alive pattern then sends edges at intervals shorter than the window, followed by silence. This separates a counter that restarts on each edge from one that merely pauses. Each exit cause is applied on its own and then in pairs. The pairs check the priority order, and check that a stuck line keeps the reset-status bit while a software reset sets it. Supply and enable are dropped from normal, and a near-miss read address is applied, to check the overrides and what must stay ignored.

// File: rtl/safemode_pkg.sv
package safemode_pkg;

  typedef enum logic [1:0] {
    MD_PWRDN = 2'd0,
    MD_STBY  = 2'd1,
    MD_SAFE  = 2'd2,
    MD_NORM  = 2'd3
  } mode_e;

  // Window length in clocks for a 2-bit selection code.
  function automatic int unsigned pick_window(input logic [1:0] sel,
                                              input int unsigned w0,
                                              input int unsigned w1,
                                              input int unsigned w2,
                                              input int unsigned w3);
    case (sel)
      2'd0:    return w0;
      2'd1:    return w1;
      2'd2:    return w2;
      default: return w3;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/safemode_wdog.sv
module safemode_wdog
  import safemode_pkg::*;
#(
  parameter int unsigned WIN0 = 2000,
  parameter int unsigned WIN1 = 10000,
  parameter int unsigned WIN2 = 50000,
  parameter int unsigned WIN3 = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       kick,
  input  logic [1:0] sel,
  output logic       expired
);

  localparam int unsigned WMAX = max4(WIN0, WIN1, WIN2, WIN3);
  localparam int         CW   = $clog2(WMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          at_end;

  assign limit   = CW'(pick_window(sel, WIN0, WIN1, WIN2, WIN3));
  assign at_end  = ({1'b0, cnt} + (CW+1)'(1)) >= {1'b0, limit};
  assign expired = run && !kick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || kick)   cnt <= '0;
    else if (!at_end)        cnt <= cnt + CW'(1);
  end

  // R5: counter stays inside the largest window
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} <= (CW+1)'(WMAX));

  // R5: an idle counter is parked at zero
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!run -> cnt == '0));

endmodule

// File: rtl/safemode_fsm.sv
module safemode_fsm
  import safemode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  supply_ok,
  input  logic  en_pin,
  input  logic  sw_evt,
  input  logic  stuck_lo,
  input  logic  tmo_hit,
  input  logic  lh_wr,
  input  logic  lh_val,
  input  logic  stat_rd,
  output mode_e mode_q,
  output logic  lh_q,
  output logic  rst_flag_q,
  output logic  clr_q
);

  mode_e nxt_mode;
  logic  nxt_lh;
  logic  set_rst;
  logic  clr_req;

  always_comb begin
    nxt_mode = mode_q;
    nxt_lh   = lh_q;
    set_rst  = 1'b0;
    clr_req  = 1'b0;
    if (!supply_ok) begin
      nxt_mode = MD_PWRDN; nxt_lh = 1'b0; set_rst = 1'b1; clr_req = 1'b1;
    end else if (!en_pin) begin
      nxt_mode = MD_STBY;  nxt_lh = 1'b0; set_rst = 1'b1; clr_req = 1'b1;
    end else begin
      case (mode_q)
        MD_PWRDN, MD_STBY: nxt_mode = MD_SAFE;
        default: begin
          if (sw_evt) begin
            nxt_mode = MD_SAFE; nxt_lh = 1'b0; set_rst = 1'b1; clr_req = 1'b1;
          end else if (stuck_lo || tmo_hit) begin
            nxt_mode = MD_SAFE; nxt_lh = 1'b0;
          end else if (lh_wr) begin
            nxt_lh   = lh_val;
            nxt_mode = lh_val ? MD_NORM : MD_SAFE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MD_PWRDN;
      lh_q       <= 1'b0;
      rst_flag_q <= 1'b1;
      clr_q      <= 1'b1;
    end else begin
      mode_q <= nxt_mode;
      lh_q   <= nxt_lh;
      clr_q  <= clr_req;
      if (set_rst)      rst_flag_q <= 1'b1;
      else if (stat_rd) rst_flag_q <= 1'b0;
    end
  end

  logic awake, active;
  assign awake  = supply_ok && en_pin;
  assign active = (mode_q == MD_SAFE) || (mode_q == MD_NORM);

  a_r1_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (mode_q == MD_PWRDN) && clr_q && !lh_q);

  a_r2_stby: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok && !en_pin |=> (mode_q == MD_STBY) && clr_q && !lh_q);

  a_r3_wake: assert property (@(posedge clk) disable iff (!rst_n)
    awake && !active |=> (mode_q == MD_SAFE));

  a_r4_norm_has_lh: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_NORM) |-> lh_q);

  a_r5_timeout_exit: assert property (@(posedge clk) disable iff (!rst_n)
    awake && tmo_hit |=> (mode_q == MD_SAFE) && !lh_q);

  a_r6_swrst: assert property (@(posedge clk) disable iff (!rst_n)
    awake && active && sw_evt |=> (mode_q == MD_SAFE) && rst_flag_q && clr_q && !lh_q);

  a_r7_stuck_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    awake && active && stuck_lo && !sw_evt
      |=> (mode_q == MD_SAFE) && !lh_q && (rst_flag_q == $past(rst_flag_q)));

  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    awake && active && sw_evt && stat_rd |=> rst_flag_q);

endmodule

// File: rtl/safemode_ctrl.sv
module safemode_ctrl
  import safemode_pkg::*;
#(
  parameter int unsigned WIN0     = 2000,
  parameter int unsigned WIN1     = 10000,
  parameter int unsigned WIN2     = 50000,
  parameter int unsigned WIN3     = 200000,
  parameter int          AW       = 6,
  parameter logic [AW-1:0] RST_ADDR = 6'h3F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          en_pin,
  input  logic          lh_wr,
  input  logic          lh_val,
  input  logic          cs_rise,
  input  logic          swrst_req,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  input  logic          status_rd,
  input  logic          sdi_stuck_lo,
  input  logic [1:0]    tmo_sel,
  output logic [1:0]    mode,
  output logic          reg_clear,
  output logic          out_release,
  output logic          lh_pin,
  output logic          lh_bit,
  output logic          rst_flag,
  output logic          sync_force_hi,
  output logic          tmo_evt
);

  mode_e mode_q;
  logic  sw_evt;
  logic  tmo_hit;
  logic  in_norm;

  assign sw_evt  = swrst_req || (rd_stb && (rd_addr == RST_ADDR));
  assign in_norm = (mode_q == MD_NORM);

  safemode_wdog #(.WIN0(WIN0), .WIN1(WIN1), .WIN2(WIN2), .WIN3(WIN3)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (in_norm),
    .kick    (cs_rise),
    .sel     (tmo_sel),
    .expired (tmo_hit)
  );

  safemode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .en_pin     (en_pin),
    .sw_evt     (sw_evt),
    .stuck_lo   (sdi_stuck_lo),
    .tmo_hit    (tmo_hit),
    .lh_wr      (lh_wr),
    .lh_val     (lh_val),
    .stat_rd    (status_rd),
    .mode_q     (mode_q),
    .lh_q       (lh_bit),
    .rst_flag_q (rst_flag),
    .clr_q      (reg_clear)
  );

  assign mode          = mode_q;
  assign lh_pin        = in_norm;
  assign out_release   = !in_norm;
  assign sync_force_hi = (mode_q == MD_SAFE);
  assign tmo_evt       = tmo_hit;

  // R8: pin levels are mutually consistent with the mode
  a_r8_pins: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lh_pin, sync_force_hi}) && (lh_pin != out_release));

  // R5: expiry only happens in normal mode
  a_r5_evt_in_norm: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |-> lh_bit && lh_pin);

endmodule

// File: tb/safemode_ctrl_bench.sv
`timescale 1ns/1ps
module safemode_ctrl_bench;

  localparam int unsigned BASE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b0, en_pin = 1'b0, lh_wr = 1'b0, lh_val = 1'b0;
  logic       cs_rise = 1'b0, swrst_req = 1'b0, rd_stb = 1'b0, status_rd = 1'b0;
  logic       sdi_stuck_lo = 1'b0;
  logic [5:0] rd_addr = 6'd0;
  logic [1:0] tmo_sel = 2'd0;
  logic [1:0] mode;
  logic       reg_clear, out_release, lh_pin, lh_bit, rst_flag, sync_force_hi, tmo_evt;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  safemode_ctrl #(.WIN0(BASE), .WIN1(BASE*2), .WIN2(BASE*4), .WIN3(BASE*8)) u_safemode_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_pin(en_pin),
    .lh_wr(lh_wr), .lh_val(lh_val), .cs_rise(cs_rise), .swrst_req(swrst_req),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .status_rd(status_rd),
    .sdi_stuck_lo(sdi_stuck_lo), .tmo_sel(tmo_sel), .mode(mode),
    .reg_clear(reg_clear), .out_release(out_release), .lh_pin(lh_pin),
    .lh_bit(lh_bit), .rst_flag(rst_flag), .sync_force_hi(sync_force_hi),
    .tmo_evt(tmo_evt)
  );

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pin levels expected from the mode alone (R8)
  task automatic chk_pins(input int m);
    chk("R8 lh_pin", int'(lh_pin), int'(m == 3));
    chk("R8 out_release", int'(out_release), int'(m != 3));
    chk("R8 sync_force_hi", int'(sync_force_hi), int'(m == 2));
  endtask

  task automatic go_normal();
    lh_wr = 1'b1; lh_val = 1'b1;
    step();
    lh_wr = 1'b0; lh_val = 1'b0;
  endtask

  task automatic clear_status();
    status_rd = 1'b1;
    step();
    status_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, evt_at;
    // reset state (R1, R9)
    step(2);
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset reg_clear", int'(reg_clear), 1);
    chk("R9 reset rst_flag", int'(rst_flag), 1);
    chk_pins(0);
    rst_n = 1'b1;
    step();
    chk("R1 stays pwrdn", int'(mode), 0);

    // R2: supply good, enable low
    supply_ok = 1'b1;
    step();
    chk("R2 standby", int'(mode), 1);
    chk("R2 reg_clear", int'(reg_clear), 1);
    chk_pins(1);

    // R3: wake into fail-safe
    en_pin = 1'b1;
    step();
    chk("R3 fail-safe", int'(mode), 2);
    chk("R3 reg_clear low", int'(reg_clear), 0);
    chk("R9 flag kept", int'(rst_flag), 1);
    chk_pins(2);
    clear_status();
    chk("R9 status read clears", int'(rst_flag), 0);

    // R5: sweep all four window codes
    for (int s = 0; s < 4; s++) begin
      tmo_sel = 2'(s);
      go_normal();
      chk("R4 enter normal", int'(mode), 3);
      chk("R4 lh_bit set", int'(lh_bit), 1);
      chk_pins(3);
      n = 1; evt_at = 0;
      if (tmo_evt) evt_at = n;
      while (mode == 2'd3 && n < 5000) begin
        step();
        if (mode == 2'd3) begin
          n++;
          if (tmo_evt && evt_at == 0) evt_at = n;
        end
      end
      chk("R5 window length", n, int'(BASE) << s);
      chk("R5 tmo_evt in last clock", evt_at, int'(BASE) << s);
      chk("R5 back to fail-safe", int'(mode), 2);
      chk("R5 lh_bit cleared", int'(lh_bit), 0);
    end

    // R5: keep-alive edges restart the window
    tmo_sel = 2'd0;
    go_normal();
    repeat (6) begin
      step(BASE - 6);
      cs_rise = 1'b1;
      step();
      cs_rise = 1'b0;
    end
    chk("R5 kept alive", int'(mode), 3);
    n = 1;
    while (mode == 2'd3 && n < 5000) begin
      step();
      if (mode == 2'd3) n++;
    end
    chk("R5 full window after edge", n, int'(BASE));

    // R4: writing 0 leaves normal
    go_normal();
    lh_wr = 1'b1; lh_val = 1'b0;
    step();
    lh_wr = 1'b0;
    chk("R4 write 0 exits", int'(mode), 2);
    chk("R4 lh_bit 0", int'(lh_bit), 0);

    // R7: stuck data line, flag untouched
    go_normal();
    sdi_stuck_lo = 1'b1;
    step();
    sdi_stuck_lo = 1'b0;
    chk("R7 stuck to fail-safe", int'(mode), 2);
    chk("R7 lh_bit 0", int'(lh_bit), 0);
    chk("R7 rst_flag unchanged", int'(rst_flag), 0);
    chk("R7 no reg_clear", int'(reg_clear), 0);

    // R6: software reset request
    go_normal();
    swrst_req = 1'b1;
    step();
    swrst_req = 1'b0;
    chk("R6 swrst mode", int'(mode), 2);
    chk("R6 swrst flag", int'(rst_flag), 1);
    chk("R6 swrst clear pulse", int'(reg_clear), 1);
    chk("R6 swrst lh", int'(lh_bit), 0);
    step();
    chk("R6 clear pulse one clock", int'(reg_clear), 0);

    // R9: entering normal keeps the flag
    go_normal();
    chk("R9 normal keeps flag", int'(rst_flag), 1);
    clear_status();
    chk("R9 cleared in normal", int'(rst_flag), 0);

    // R6: near-miss read ignored, reserved read resets
    rd_stb = 1'b1; rd_addr = 6'h3E;
    step();
    chk("R6 other read ignored", int'(mode), 3);
    chk("R6 other read flag", int'(rst_flag), 0);
    rd_addr = 6'h3F;
    step();
    rd_stb = 1'b0; rd_addr = 6'h00;
    chk("R6 reserved read mode", int'(mode), 2);
    chk("R6 reserved read flag", int'(rst_flag), 1);

    // R10: stuck beats limp-home write
    lh_wr = 1'b1; lh_val = 1'b1; sdi_stuck_lo = 1'b1;
    step();
    lh_wr = 1'b0; lh_val = 1'b0; sdi_stuck_lo = 1'b0;
    chk("R10 stuck over write", int'(mode), 2);
    chk("R10 lh stays 0", int'(lh_bit), 0);
    // R10: flag set beats status read
    clear_status();
    swrst_req = 1'b1; status_rd = 1'b1;
    step();
    swrst_req = 1'b0; status_rd = 1'b0;
    chk("R10 set beats clear", int'(rst_flag), 1);
    // R10: swrst beats timeout at expiry
    clear_status();
    go_normal();
    step(BASE - 1);
    chk("R10 timeout pending", int'(tmo_evt), 1);
    swrst_req = 1'b1;
    step();
    swrst_req = 1'b0;
    chk("R10 swrst over timeout", int'(rst_flag), 1);
    chk("R10 swrst pulse", int'(reg_clear), 1);

    // R2: enable dropped from normal
    go_normal();
    en_pin = 1'b0;
    step();
    chk("R2 enable drop", int'(mode), 1);
    chk("R2 lh cleared", int'(lh_bit), 0);
    en_pin = 1'b1;
    step();
    chk("R3 rewake", int'(mode), 2);

    // R1: supply loss overrides enable
    clear_status();
    go_normal();
    supply_ok = 1'b0;
    step();
    chk("R1 supply loss", int'(mode), 0);
    chk("R1 flag set", int'(rst_flag), 1);
    chk("R1 lh cleared", int'(lh_bit), 0);
    chk_pins(0);
    supply_ok = 1'b1;
    step();
    chk("R3 from pwrdn", int'(mode), 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule